// File: doc/BRIEF.md
# Dual 32-bit Timer Pair

The block holds two independent 32-bit up-counters, called the lower half and the upper half. Each half has its own counter, its own period and its own interrupt line. Each half's counter advances by one on every clock while it runs. When the count equals the period, the half raises its interrupt for one clock. In periodic mode the counter then starts again from zero. In one-shot mode the half switches itself off.

Software drives the block through a simple register bus. A write is one cycle with a write strobe, an address and data. A read is combinational: the read data follows the address in the same cycle, and no strobe is needed. A shared control word holds each half's 2-bit enable field. A global control word selects the timer mode and holds one release bit for each half. Only the unchained 32-bit mode makes the counters run. Chained 64-bit counting, prescaling, external clocks and the watchdog function are outside this block.

Top module: `tmr_pair`

## Requirements
- R1: After `rst_ni` is asserted, every counter, period, enable field and global control bit reads 0, both interrupt outputs are low, and address 0x00 returns the `ID_VAL` parameter.
- R2: The register addresses are as follows. Address 0x10 is the lower counter and 0x14 the upper counter. Address 0x18 is the lower period and 0x1C the upper period. Address 0x20 is the control word, with the lower enable field in bits [7:6] and the upper enable field in bits [23:22]. Address 0x24 is the global control word: bit 0 releases the lower half, bit 1 releases the upper half, and bits [3:2] hold the mode. Unused bits, address 0x28 and any unmapped address read as 0.
- R3: An enable field value of 0 means off, 1 means one-shot and 2 means periodic. The value 3 behaves as off. A running half adds exactly 1 to its counter per clock, and a half that is off holds its counter value.
- R4: In periodic mode, a cycle in which count equals period makes that half's interrupt high during the next cycle only, and the counter is 0 in that next cycle.
- R5: In one-shot mode, the match produces the same one-cycle interrupt. The half's enable field then reads 0 and its counter stays at the period value.
- R6: A periodic half whose period is 0xFFFFFFFF counts up to 0xFFFFFFFF, raises its interrupt, and then continues from 0.
- R7: While a half's release bit is 0, its counter is forced to 0 and writes to that counter are discarded. Writes to its period and enable field are still kept.
- R8: A bus write to a released half's counter loads the written value in place of the increment for that cycle. Counting then continues from the loaded value.
- R9: With the mode bits [3:2] at any value other than 1, both counters hold their values and no interrupt is raised, even when a half is released and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Combinational read data for `bus_addr_i` |
| irq_lo_o | output | 1 | Lower half match interrupt, high for one clock per match |
| irq_hi_o | output | 1 | Upper half match interrupt, high for one clock per match |

## Verification
The main function is tested with both halves running at the same time: the lower half is periodic with a short period and the upper half is one-shot. This tests whether the halves are truly independent and whether the one-shot self-clear leaves the periodic half untouched. A run near the top of the 32-bit range, with an all-ones period, separates a correct wrap from an early or missing match. A counter load in the middle of a run checks that a write takes the place of the increment rather than adding to it. Runs with a half held in reset, with a mode other than unchained, and with the reserved enable value each check that the counter stays frozen. A behavioural model follows both halves on every clock, and any interrupt that is missing or extra is reported.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    // Enable-field encoding, shared by both halves
    typedef enum logic [1:0] {
        EN_OFF  = 2'd0,
        EN_ONCE = 2'd1,
        EN_LOOP = 2'd2,
        EN_RSVD = 2'd3
    } en_mode_e;

    // Global mode select; only the unchained value makes the counters run
    localparam logic [1:0] GMODE_UNCHAINED = 2'd1;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_PRD_LO = 8'h18;
    localparam logic [7:0] OFS_PRD_HI = 8'h1C;
    localparam logic [7:0] OFS_CTRL   = 8'h20;
    localparam logic [7:0] OFS_GCTL   = 8'h24;

    // Field positions
    localparam int unsigned EN_LO_LSB = 6;
    localparam int unsigned EN_HI_LSB = 22;
    localparam int unsigned GCTL_W    = 4;

endpackage

// File: rtl/tmr_half.sv
module tmr_half
    import tmr_pair_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rel_i,       // 1 = released from reset
    input  logic             run_mode_i,  // global mode allows counting
    input  logic             cnt_we_i,
    input  logic             prd_we_i,
    input  logic             en_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  en_mode_e         en_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] prd_o,
    output en_mode_e         en_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
        en_mode_e         en;
        logic             irq;
    } half_s;

    half_s s_d, s_q;
    logic  active;
    logic  hit;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        active  = run_mode_i && ((s_q.en == EN_ONCE) || (s_q.en == EN_LOOP));
        hit     = (s_q.cnt == s_q.prd);

        if (prd_we_i) begin
            s_d.prd = wdata_i;
        end

        if (!rel_i) begin
            s_d.cnt = '0;
        end else if (cnt_we_i) begin
            s_d.cnt = wdata_i;
        end else if (active) begin
            if (hit) begin
                s_d.irq = 1'b1;
                if (s_q.en == EN_LOOP) begin
                    s_d.cnt = '0;
                end else begin
                    s_d.en = EN_OFF;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        // a software write to the enable field wins over the one-shot self-clear
        if (en_we_i) begin
            s_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign prd_o = s_q.prd;
    assign en_o  = s_q.en;
    assign irq_o = s_q.irq;

endmodule

// File: rtl/tmr_regmap.sv
module tmr_regmap
    import tmr_pair_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32,
    parameter logic [CNT_W-1:0] ID_VAL = '0
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_lo_i,
    input  logic [CNT_W-1:0]  cnt_hi_i,
    input  logic [CNT_W-1:0]  prd_lo_i,
    input  logic [CNT_W-1:0]  prd_hi_i,
    input  en_mode_e          en_lo_i,
    input  en_mode_e          en_hi_i,
    input  logic [GCTL_W-1:0] gctl_i,
    output logic [1:0]        cnt_we_o,
    output logic [1:0]        prd_we_o,
    output logic              ctrl_we_o,
    output logic              gctl_we_o,
    output logic [CNT_W-1:0]  rdata_o
);

    assign cnt_we_o[0] = wr_i && (addr_i == ADDR_W'(OFS_CNT_LO));
    assign cnt_we_o[1] = wr_i && (addr_i == ADDR_W'(OFS_CNT_HI));
    assign prd_we_o[0] = wr_i && (addr_i == ADDR_W'(OFS_PRD_LO));
    assign prd_we_o[1] = wr_i && (addr_i == ADDR_W'(OFS_PRD_HI));
    assign ctrl_we_o   = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
    assign gctl_we_o   = wr_i && (addr_i == ADDR_W'(OFS_GCTL));

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFS_ID):     rdata_o = ID_VAL;
            ADDR_W'(OFS_CNT_LO): rdata_o = cnt_lo_i;
            ADDR_W'(OFS_CNT_HI): rdata_o = cnt_hi_i;
            ADDR_W'(OFS_PRD_LO): rdata_o = prd_lo_i;
            ADDR_W'(OFS_PRD_HI): rdata_o = prd_hi_i;
            ADDR_W'(OFS_CTRL): begin
                rdata_o[EN_LO_LSB +: 2] = en_lo_i;
                rdata_o[EN_HI_LSB +: 2] = en_hi_i;
            end
            ADDR_W'(OFS_GCTL):   rdata_o[GCTL_W-1:0] = gctl_i;
            default:             rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32,
    parameter logic [CNT_W-1:0] ID_VAL = 32'h0044_0701
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              irq_lo_o,
    output logic              irq_hi_o
);

    localparam int unsigned NUM_HALF = 2;

    logic [GCTL_W-1:0] gctl_d, gctl_q;
    logic [1:0]        cnt_we, prd_we;
    logic              ctrl_we, gctl_we;
    logic              run_mode;
    logic [CNT_W-1:0]  cnt_w [NUM_HALF];
    logic [CNT_W-1:0]  prd_w [NUM_HALF];
    en_mode_e          en_w  [NUM_HALF];
    logic [NUM_HALF-1:0] irq_w;

    always_comb begin
        gctl_d = gctl_q;
        if (gctl_we) begin
            gctl_d = bus_wdata_i[GCTL_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gctl_q <= '0;
        end else begin
            gctl_q <= gctl_d;
        end
    end

    assign run_mode = (gctl_q[3:2] == GMODE_UNCHAINED);

    for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
        localparam int unsigned LSB = (g == 0) ? EN_LO_LSB : EN_HI_LSB;
        tmr_half #(.CNT_W(CNT_W)) u_half (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .rel_i      (gctl_q[g]),
            .run_mode_i (run_mode),
            .cnt_we_i   (cnt_we[g]),
            .prd_we_i   (prd_we[g]),
            .en_we_i    (ctrl_we),
            .wdata_i    (bus_wdata_i),
            .en_wdata_i (en_mode_e'(bus_wdata_i[LSB +: 2])),
            .cnt_o      (cnt_w[g]),
            .prd_o      (prd_w[g]),
            .en_o       (en_w[g]),
            .irq_o      (irq_w[g])
        );
    end

    tmr_regmap #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .ID_VAL (ID_VAL)
    ) u_regmap (
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .cnt_lo_i  (cnt_w[0]),
        .cnt_hi_i  (cnt_w[1]),
        .prd_lo_i  (prd_w[0]),
        .prd_hi_i  (prd_w[1]),
        .en_lo_i   (en_w[0]),
        .en_hi_i   (en_w[1]),
        .gctl_i    (gctl_q),
        .cnt_we_o  (cnt_we),
        .prd_we_o  (prd_we),
        .ctrl_we_o (ctrl_we),
        .gctl_we_o (gctl_we),
        .rdata_o   (bus_rdata_o)
    );

    assign irq_lo_o = irq_w[0];
    assign irq_hi_o = irq_w[1];

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic [CNT_W-1:0]  cnt_lo,
    input logic [CNT_W-1:0]  cnt_hi,
    input logic [1:0]        en_lo,
    input logic [1:0]        en_hi,
    input logic [3:0]        gctl
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!irq_lo && !irq_hi));

    // R7
    held_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gctl[0] |=> (cnt_lo == '0));

    // R7
    held_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gctl[1] |=> (cnt_hi == '0));

    // R9
    idle_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((gctl[3:2] != 2'd1) && gctl[0] && !(wr_i && (addr_i == ADDR_W'(8'h10))))
        |=> $stable(cnt_lo));

    // R3
    off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((en_hi == 2'd0) && gctl[1] && !(wr_i && (addr_i == ADDR_W'(8'h14))))
        |=> $stable(cnt_hi));

    // R4
    irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_lo |-> (($past(en_lo) == 2'd1) || ($past(en_lo) == 2'd2)));

endmodule

bind tmr_pair tmr_pair_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .irq_lo (irq_lo_o),
    .irq_hi (irq_hi_o),
    .cnt_lo (cnt_w[0]),
    .cnt_hi (cnt_w[1]),
    .en_lo  (en_w[0]),
    .en_hi  (en_w[1]),
    .gctl   (gctl_q)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;

    localparam logic [31:0] ID_EXP = 32'h0044_0701;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bwr = 1'b0;
    logic [7:0]  baddr = 8'h00;
    logic [31:0] bwd = '0;
    logic [31:0] brd;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_pair #(.ID_VAL(ID_EXP)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (bwr),
        .bus_addr_i  (baddr),
        .bus_wdata_i (bwd),
        .bus_rdata_o (brd),
        .irq_lo_o    (irq_lo),
        .irq_hi_o    (irq_hi)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cnt [2];
    logic [31:0] m_prd [2];
    logic [1:0]  m_en  [2];
    logic        m_irq [2];
    logic [3:0]  m_gc;
    logic [3:0]  gc_old;

    function automatic int en_lsb(int h);
        return (h == 0) ? 6 : 22;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int h = 0; h < 2; h++) begin
                m_cnt[h] = '0; m_prd[h] = '0; m_en[h] = '0; m_irq[h] = 1'b0;
            end
            m_gc = '0;
        end else begin
            gc_old = m_gc;
            if (bwr && baddr == 8'h24) m_gc = bwd[3:0];
            for (int h = 0; h < 2; h++) begin
                m_irq[h] = 1'b0;
                if (!gc_old[h])
                    m_cnt[h] = '0;
                else if (bwr && baddr == ((h == 0) ? 8'h10 : 8'h14))
                    m_cnt[h] = bwd;
                else if (gc_old[3:2] == 2'd1 && (m_en[h] == 2'd1 || m_en[h] == 2'd2)) begin
                    if (m_cnt[h] == m_prd[h]) begin
                        m_irq[h] = 1'b1;
                        if (m_en[h] == 2'd2) m_cnt[h] = '0;
                        else m_en[h] = 2'd0;
                    end else begin
                        m_cnt[h] = m_cnt[h] + 32'd1;
                    end
                end
                if (bwr && baddr == ((h == 0) ? 8'h18 : 8'h1C)) m_prd[h] = bwd;
                if (bwr && baddr == 8'h20) m_en[h] = bwd[en_lsb(h) +: 2];
            end
        end
    end

    // per-clock interrupt comparison against the model (R4/R5/R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_lo !== m_irq[0] || irq_hi !== m_irq[1]) begin
                fails++;
                $display("FAIL R4/R5 irq lo/hi actual %0b%0b expected %0b%0b at %0t",
                         irq_lo, irq_hi, m_irq[0], m_irq[1], $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bwr = 1'b1; baddr = a; bwd = d;
        @(negedge clk);
        bwr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bwr = 1'b0; baddr = a;
        #1;
        checks++;
        if (brd !== exp) begin
            fails++;
            $display("FAIL %s addr %02h actual %08h expected %08h", tag, a, brd, exp);
        end
    endtask

    task automatic bit_chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    logic [31:0] snap;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd_chk(8'h00, ID_EXP, "R1 id");
        rd_chk(8'h10, 32'h0, "R1 cnt lo");
        rd_chk(8'h1C, 32'h0, "R1 prd hi");
        rd_chk(8'h20, 32'h0, "R1 ctrl");
        rd_chk(8'h24, 32'h0, "R1 gctl");
        bit_chk(irq_lo | irq_hi, 1'b0, "R1 irq");
        rd_chk(8'h28, 32'h0, "R2 wd slot");

        // configure while both halves are held (R7)
        wr(8'h18, 32'd4);
        wr(8'h1C, 32'd3);
        wr(8'h20, (32'd2 << 6) | (32'd1 << 22));
        wr(8'h24, 32'h4);
        idle(6);
        rd_chk(8'h10, 32'h0, "R7 held cnt");
        wr(8'h10, 32'd9);
        rd_chk(8'h10, 32'h0, "R7 write discarded");
        rd_chk(8'h18, 32'd4, "R7 prd kept");
        rd_chk(8'h20, 32'h0040_0080, "R2 ctrl fields");
        rd_chk(8'h24, 32'h4, "R2 gctl");

        // release both: lower periodic, upper one-shot (R4, R5)
        wr(8'h24, 32'h7);
        idle(13);
        rd_chk(8'h14, 32'd3, "R5 one-shot holds at period");
        rd_chk(8'h20, 32'h0000_0080, "R5 upper enable cleared");
        rd_chk(8'h10, m_cnt[0], "R4 periodic count");
        idle(2);
        rd_chk(8'h14, 32'd3, "R5 stays stopped");

        // non-unchained mode freezes both (R9)
        wr(8'h24, 32'h3);
        snap = m_cnt[0];
        idle(6);
        rd_chk(8'h10, snap, "R9 counter frozen");
        bit_chk(irq_lo, 1'b0, "R9 no irq");

        // wrap with all-ones period (R6)
        wr(8'h24, 32'h7);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFD);
        idle(2);
        rd_chk(8'h10, 32'hFFFF_FFFF, "R6 reaches top");
        idle(1);
        rd_chk(8'h10, 32'h0, "R6 wraps to zero");
        bit_chk(irq_lo, 1'b1, "R6 irq at top");
        idle(1);
        rd_chk(8'h10, 32'h1, "R3 counts on after wrap");

        // counter load mid-run (R8)
        wr(8'h10, 32'd100);
        rd_chk(8'h10, 32'd100, "R8 load replaces increment");
        idle(3);
        rd_chk(8'h10, 32'd103, "R3 one per clock");

        // reserved enable value behaves as off (R3)
        wr(8'h20, 32'd3 << 6);
        snap = m_cnt[0];
        idle(4);
        rd_chk(8'h10, snap, "R3 reserved value idle");
        rd_chk(8'h20, 32'h0000_00C0, "R3 reserved readback");

        // back to periodic, re-hold lower half (R7)
        wr(8'h20, 32'd2 << 6);
        wr(8'h24, 32'h6);
        idle(2);
        rd_chk(8'h10, 32'h0, "R7 hold clears counter");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule